// File: doc/BRIEF.md
# Audio Sample Streaming Engine

This block streams audio samples between a word-addressed memory and a pair of converters without any help from the processor. A rate generator steps an 11-bit maximal-length shift register every clock. It produces a sample tick whenever the register reaches its terminal state. On each tick the engine does one read-modify-write of a single 20-bit memory word. The upper seven bits of the word are latched onto the DAC output. The six low bits are replaced with the converted ADC sample, and the word is written back. If the word carries an interrupt flag, an interrupt request is raised.

Software sets the sample interval, turns the engine on and off, and can re-aim the address pointer. All of this goes through one control word. The address pointer only advances inside a 1024-word page, so playback loops over a page. The ADC code passes through a 64-entry remap table before it is stored.

The memory side is a valid/ready pair: `mem_req` is valid and `mem_ack` is ready. Once `mem_req` is raised, the engine keeps `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is seen. Read data is taken from `mem_rdata` in that same cycle. The address-load input is also valid/ready. The producer holds `ld_valid` and `ld_addr` until a cycle with `ld_ready` high, and the transfer happens in that cycle.

Top module: `audio_sample_dma`

## Requirements
- R1: The rate register steps each clock as new = {old[9:0], old[10] ^ old[8]}. When it equals 11'h7FF, it reloads from the rate field and one tick is issued in that cycle. A rate value that needs k steps to reach 11'h7FF gives k+1 clocks between ticks. A rate field of 11'h7FF gives a tick every clock.
- R2: A write with `ctl_we` loads the control word. The rate field is in bits 16:6, enable in bit 18 and address-load in bit 1. Enable is 0 after reset. While enable is 0, no tick occurs and no memory access starts.
- R3: Each tick that finds the engine idle performs exactly one read followed by one write to the same address. The written word equals the read word with only bits 5:0 replaced.
- R4: When the read completes, bits 19:13 of the read word appear on `dac_out`, which holds them until the next read completes.
- R5: The new bits 5:0 are the remap-table entry indexed by `adc_code`, sampled in the read's acknowledge cycle. The table holds the identity mapping after reset, and `lut_we` writes `lut_data` into entry `lut_idx`.
- R6: After each write the address increments only in bits 9:0, and bits 20:10 are kept. For example, 0FFFFF is followed by 0FFC00.
- R7: A read word with bit 10 set raises `irq` on the next clock. `irq` stays high until a cycle with `irq_ack`, after which it is low.
- R8: `ld_ready` is high only while the address-load bit is set, the engine is idle and no tick is being issued. A transfer loads the address with the page-increment of `ld_addr` and clears the load bit. Rate and enable are left unchanged.
- R9: After an address load, the next sample read is from the loaded address plus one.
- R10: A tick that arrives while an access is in progress pulses `overrun` for that cycle and starts no further access.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` do not change.
- R12: After reset, `mem_req`, `irq`, `overrun`, `ld_ready` and `dac_out` are 0, and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 20 | Control word: rate 16:6, enable 18, address-load 1 |
| ld_valid | input | 1 | Address-load valid |
| ld_addr | input | 21 | Address offered for loading |
| ld_ready | output | 1 | Address-load ready |
| lut_we | input | 1 | Remap table write strobe |
| lut_idx | input | 6 | Remap table write index |
| lut_data | input | 6 | Remap table write value |
| adc_code | input | 6 | ADC sample code |
| dac_out | output | 7 | Latched DAC code |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| overrun | output | 1 | Pulse when a tick is dropped |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 21 | Memory word address |
| mem_wdata | output | 20 | Memory write data |
| mem_ack | input | 1 | Memory ready / acknowledge |
| mem_rdata | input | 20 | Memory read data, valid with `mem_ack` on reads |

## Verification
Several properties are checked on every cycle. The memory request stays stable under back-pressure. Every acknowledged read is followed by a write to the same address. The page bits never change on an increment. The rate register reloads after each tick. A disabled engine never raises a request. An interrupt only rises after a flagged read, and a completed address load clears its bit. The bench scenarios cover what needs computed values: the actual tick spacing for a chosen rate, the merged write-back word through both the identity and the rewritten table, the DAC code, wrap at a page end, the sample that follows an address load, and drop behaviour at the fastest rate.

// File: rtl/aud_pkg.sv
`timescale 1ns/1ps
package aud_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } sq_state_t;
endpackage

// File: rtl/aud_rate_gen.sv
`timescale 1ns/1ps
module aud_rate_gen #(
  parameter int LFSR_W = 11,
  parameter int TAP_A  = 10,
  parameter int TAP_B  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LFSR_W-1:0] rate,
  output logic              tick
);
  localparam logic [LFSR_W-1:0] TERMINAL = {LFSR_W{1'b1}};

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_step;

  assign lfsr_step = {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_A] ^ lfsr_q[TAP_B]};
  assign tick      = en && (lfsr_q == TERMINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lfsr_q <= '0;
    else if (!en || tick)     lfsr_q <= rate;
    else                      lfsr_q <= lfsr_step;
  end

  // R1: each tick is followed by a reload from the rate field
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (lfsr_q == $past(rate)));
endmodule

// File: rtl/aud_lut.sv
`timescale 1ns/1ps
module aud_lut #(
  parameter int IDX_W = 6,
  parameter int VAL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VAL_W-1:0] tbl [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= VAL_W'(i);
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_val;
    end
  end

  assign rd_val = tbl[rd_idx];
endmodule

// File: rtl/aud_seq.sv
`timescale 1ns/1ps
module aud_seq
  import aud_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int WORD_W = 20,
  parameter int PAGE_W = 10,
  parameter int SAMP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_en,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_ready,
  input  logic [SAMP_W-1:0] samp_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rd_done,
  output logic              overrun
);
  sq_state_t         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              rd_unused;

  function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a);
    page_inc = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  assign rd_unused = ^mem_rdata[SAMP_W-1:0];
  assign ld_ready  = ld_en && (st_q == SQ_IDLE) && !tick;
  assign mem_req   = (st_q != SQ_IDLE);
  assign mem_we    = (st_q == SQ_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rd_done   = (st_q == SQ_READ) && mem_ack;
  assign overrun   = tick && (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (ld_valid && ld_ready) addr_q <= page_inc(ld_addr);
          else if (tick)            st_q   <= SQ_READ;
        end
        SQ_READ: begin
          if (mem_ack) begin
            wdata_q <= {mem_rdata[WORD_W-1:SAMP_W], samp_val};
            st_q    <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          if (mem_ack) begin
            addr_q <= page_inc(addr_q);
            st_q   <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R11: request held steady under back-pressure
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R3: an accepted read is followed by a write to the same word
  p_rmw_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_addr == $past(mem_addr)));

  // R6: increments never leave the page
  p_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/audio_sample_dma.sv
`timescale 1ns/1ps
module audio_sample_dma #(
  parameter int WORD_W   = 20,
  parameter int ADDR_W   = 21,
  parameter int PAGE_W   = 10,
  parameter int LFSR_W   = 11,
  parameter int SAMP_W   = 6,
  parameter int DAC_W    = 7,
  parameter int RATE_LSB = 6,
  parameter int EN_BIT   = 18,
  parameter int LD_BIT   = 1,
  parameter int IRQ_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_ready,
  input  logic              lut_we,
  input  logic [SAMP_W-1:0] lut_idx,
  input  logic [SAMP_W-1:0] lut_data,
  input  logic [SAMP_W-1:0] adc_code,
  output logic [DAC_W-1:0]  dac_out,
  output logic              irq,
  input  logic              irq_ack,
  output logic              overrun,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int RATE_MSB = RATE_LSB + LFSR_W - 1;

  logic [LFSR_W-1:0] rate_q;
  logic              en_q;
  logic              load_q;
  logic              tick;
  logic              rd_done;
  logic [SAMP_W-1:0] samp_val;
  logic [DAC_W-1:0]  dac_q;
  logic              irq_q;
  logic              ctl_unused;

  assign ctl_unused = ^ctl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      en_q   <= 1'b0;
      load_q <= 1'b0;
    end else if (ctl_we) begin
      rate_q <= ctl_wdata[RATE_MSB:RATE_LSB];
      en_q   <= ctl_wdata[EN_BIT];
      load_q <= ctl_wdata[LD_BIT];
    end else if (ld_valid && ld_ready) begin
      load_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_done) dac_q <= mem_rdata[WORD_W-1 -: DAC_W];
      if (rd_done && mem_rdata[IRQ_BIT]) irq_q <= 1'b1;
      else if (irq_ack)                  irq_q <= 1'b0;
    end
  end

  assign dac_out = dac_q;
  assign irq     = irq_q;

  aud_rate_gen #(.LFSR_W(LFSR_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en_q),
    .rate (rate_q),
    .tick (tick)
  );

  aud_lut #(.IDX_W(SAMP_W), .VAL_W(SAMP_W)) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (lut_we),
    .wr_idx(lut_idx),
    .wr_val(lut_data),
    .rd_idx(adc_code),
    .rd_val(samp_val)
  );

  aud_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W), .SAMP_W(SAMP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ld_en    (load_q),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_ready (ld_ready),
    .samp_val (samp_val),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .rd_done  (rd_done),
    .overrun  (overrun)
  );

  // R2: with the engine off, an idle port stays idle
  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !mem_req) |=> !mem_req);

  // R7: the interrupt only rises after a flagged read
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rd_done && mem_rdata[IRQ_BIT]));

  // R8: a completed address load drops the load bit
  p_ld_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !ctl_we) |=> !load_q);
endmodule

// File: tb/audio_sample_dma_test.sv
`timescale 1ns/1ps
module audio_sample_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [19:0] ctl_wdata = '0;
  logic        ld_valid = 1'b0;
  logic [20:0] ld_addr = '0;
  logic        ld_ready;
  logic        lut_we = 1'b0;
  logic [5:0]  lut_idx = '0;
  logic [5:0]  lut_data = '0;
  logic [5:0]  adc_code = '0;
  logic [6:0]  dac_out;
  logic        irq;
  logic        irq_ack = 1'b0;
  logic        overrun;
  logic        mem_req;
  logic        mem_we;
  logic [20:0] mem_addr;
  logic [19:0] mem_wdata;
  logic        mem_ack;
  logic [19:0] mem_rdata;

  always #2 clk = ~clk;

  audio_sample_dma uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .lut_we(lut_we), .lut_idx(lut_idx), .lut_data(lut_data), .adc_code(adc_code),
    .dac_out(dac_out), .irq(irq), .irq_ack(irq_ack), .overrun(overrun),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model and access log
  logic [19:0] mem [logic [20:0]];
  int          lat = 0;
  int          wait_cnt = 0;
  int          nrd = 0, nwr = 0, seq_err = 0, stall_err = 0;
  logic [20:0] last_rd_addr = '0, last_wr_addr = '0, hold_addr = '0;
  logic        hold_we = 1'b0, pend_rd = 1'b0;

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (wait_cnt == 0) begin
          hold_addr = mem_addr;
          hold_we   = mem_we;
        end else if (mem_addr !== hold_addr || mem_we !== hold_we) begin
          stall_err++;
        end
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          mem_ack  = 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            nwr++;
            last_wr_addr = mem_addr;
            if (!pend_rd) seq_err++;
            pend_rd = 1'b0;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 20'h0;
            nrd++;
            last_rd_addr = mem_addr;
            if (pend_rd) seq_err++;
            pend_rd = 1'b1;
          end
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] lfsr_back(input logic [10:0] s);
    return {s[0] ^ s[9], s[10:1]};
  endfunction

  logic [10:0] rate10;  // value needing 9 steps to reach 7FF: 10-clock period

  task automatic ctl_write(input logic [10:0] rate, input logic en, input logic ld);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = (20'(en) << 18) | (20'(rate) << 6) | (20'(ld) << 1);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic load_addr(input logic [20:0] a);
    int t;
    ctl_write(rate10, 1'b0, 1'b1);
    ld_valid = 1'b1;
    ld_addr  = a;
    t = 0;
    while (!ld_ready && t < 100) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_one();
    int n0, t;
    n0 = nwr;
    ctl_write(rate10, 1'b1, 1'b0);
    t = 0;
    while (nwr == n0 && t < 500) begin
      @(negedge clk);
      t++;
    end
    ctl_write(rate10, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 mem_req", 32'(mem_req), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 dac_out", 32'(dac_out), 0);
    chk("R12 overrun", 32'(overrun), 0);
    chk("R12 ld_ready", 32'(ld_ready), 0);
    chk("R12 address", 32'(mem_addr), 0);
    repeat (40) @(negedge clk);
    chk("R2 no access while disabled", 32'(nrd), 0);
  endtask

  task automatic t_rate();
    int c0, c1, n, t;
    ctl_write(rate10, 1'b0, 1'b0);
    ctl_write(rate10, 1'b1, 1'b0);
    n = nrd; t = 0;
    while (nrd == n && t < 200) begin @(negedge clk); t++; end
    c0 = cyc;
    for (int k = 0; k < 3; k++) begin
      n = nrd; t = 0;
      while (nrd == n && t < 200) begin @(negedge clk); t++; end
      c1 = cyc;
      chk("R1 tick spacing", 32'(c1 - c0), 10);
      c0 = c1;
    end
    ctl_write(rate10, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    n = nrd;
    repeat (30) @(negedge clk);
    chk("R2 disable stops access", 32'(nrd - n), 0);
  endtask

  task automatic t_rmw();
    logic [19:0] d;
    d = 20'hB3A9E;
    mem[21'h41] = d;
    adc_code = 6'h15;
    load_addr(21'h40);
    run_one();
    chk("R9 read after load", 32'(last_rd_addr), 32'h41);
    chk("R3 write same address", 32'(last_wr_addr), 32'h41);
    chk("R5 identity merge", 32'(mem[21'h41]), 32'((d & ~20'h3F) | 20'h15));
    chk("R4 dac code", 32'(dac_out), 32'(d >> 13));
    chk("R7 no irq without flag", 32'(irq), 0);
    run_one();
    chk("R6 next address", 32'(last_rd_addr), 32'h42);
    chk("R4 dac updates", 32'(dac_out), 0);
  endtask

  task automatic t_irq();
    mem[21'h101] = 20'h00400;
    load_addr(21'h100);
    run_one();
    chk("R7 irq raised", 32'(irq), 1);
    repeat (5) @(negedge clk);
    chk("R7 irq held", 32'(irq), 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R7 irq cleared", 32'(irq), 0);
    run_one();
    chk("R7 no irq on clear word", 32'(irq), 0);
  endtask

  task automatic t_lut();
    @(negedge clk);
    lut_we = 1'b1; lut_idx = 6'h2A; lut_data = 6'h07;
    @(negedge clk);
    lut_we = 1'b0;
    mem[21'h301] = 20'hFFFFF;
    adc_code = 6'h2A;
    load_addr(21'h300);
    run_one();
    chk("R5 remapped entry", 32'(mem[21'h301]), 32'h000FFFC7);
  endtask

  task automatic t_page();
    load_addr(21'h0FFFFE);
    run_one();
    chk("R6 page end read", 32'(last_rd_addr), 32'h0FFFFF);
    run_one();
    chk("R6 page wrap", 32'(last_rd_addr), 32'h0FFC00);
  endtask

  task automatic t_load_live();
    int n, t, c0;
    ctl_write(rate10, 1'b1, 1'b1);
    ld_valid = 1'b1; ld_addr = 21'h200; t = 0;
    while (!ld_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R8 ready drops after load", 32'(ld_ready), 0);
    n = nrd; t = 0;
    while (nrd == n && t < 200) begin @(negedge clk); t++; end
    c0 = cyc;
    chk("R9 first sample after live load", 32'(last_rd_addr), 32'h201);
    n = nrd; t = 0;
    while (nrd == n && t < 200) begin @(negedge clk); t++; end
    chk("R8 rate kept", 32'(cyc - c0), 10);
    chk("R8 enable kept", 32'(last_rd_addr), 32'h202);
    ctl_write(rate10, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_overrun();
    int ov, r0;
    ov = 0;
    r0 = nrd;
    ctl_write(11'h7FF, 1'b1, 1'b0);
    repeat (40) begin
      @(negedge clk);
      if (overrun) ov++;
    end
    ctl_write(11'h7FF, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R10 overrun seen", 32'(ov > 0), 1);
    chk("R10 reads limited by busy", 32'((nrd - r0) < 15), 1);
    chk("R10 no extra access", 32'(seq_err), 0);
    chk("R3 reads equal writes", 32'(nrd), 32'(nwr));
  endtask

  task automatic t_backpressure();
    lat = 3;
    mem[21'h401] = 20'h5A5A5;
    adc_code = 6'h3C;
    load_addr(21'h400);
    run_one();
    lat = 0;
    chk("R11 stable under stall", 32'(stall_err), 0);
    chk("R11 stalled write value", 32'(mem[21'h401]), 32'((20'h5A5A5 & ~20'h3F) | 20'h3C));
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rate10 = 11'h7FF;
    for (int k = 0; k < 9; k++) rate10 = lfsr_back(rate10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate();
    t_rmw();
    t_irq();
    t_lut();
    t_page();
    t_load_live();
    t_overrun();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule